// File: doc/BRIEF.md
# Phased Line-Decimating Video Capture Controller

This block sits between a digital video decoder and a buffer that holds one line, and decides which decoded bytes reach that buffer. Each capture keeps one active line out of every four in both fields of an interlaced frame. The line phase moves on by one after every capture, so four captures in a row together deliver every line of the frame exactly once. The host then has several line periods to empty the buffer between two selected lines.

The host pulses a capture request. The capture starts at the next odd-field start, runs through that odd field and the even field after it, and ends at the next vertical sync. The phase then advances modulo four. For each selected line the block forwards every byte of the active period, one clock late. When the line ends it raises an interrupt that stays high until it is acknowledged. Two sticky flags report a selected line that began while the interrupt was still pending, and a selected line whose byte count was not the nominal line length.

Top module: `phased_line_capture`

## Requirements
- R1: While reset is high and in the cycle after it, buf_we, irq, ovr_flag and len_err are 0 and phase is 0.
- R2: Outside a capture, no byte is written. This covers fields before any request and fields after a capture has ended.
- R3: A request arms the block, and the capture begins at the first field start (vsync falling) with field_odd=1, the code for the odd field. An even-field start (field_odd=0) that comes after the request writes nothing.
- R4: Within a field, the line index counts href rising edges since vsync, starting at 0. During a capture, a line whose index modulo 4 equals phase is written in full and in order: buf_we=1 and buf_data equal pix_data, both one clock after each href-high cycle. Other lines are not written.
- R5: phase changes only at the vsync rising edge that ends a capture. It then increments by one, wrapping from 3 to 0.
- R6: Four consecutive captures write every line of both fields exactly once.
- R7: irq rises after each selected line ends and stays high until irq_ack is 1. One capture of two fields of L lines raises irq 2·L/4 times.
- R8: ovr_flag becomes 1, and stays 1 until reset, when a selected line starts while irq is high and not being acknowledged. It stays 0 when every interrupt is acknowledged in time.
- R9: len_err becomes 1, and stays 1 until reset, when a selected line has fewer or more bytes than BYTES_PER_LINE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | DATA_W | Decoder byte stream |
| href | input | 1 | High during the active bytes of a line |
| vsync | input | 1 | Vertical sync, high between fields |
| field_odd | input | 1 | 1 = odd field, 0 = even field, valid at the vsync falling edge |
| cap_req | input | 1 | Host capture request pulse |
| irq_ack | input | 1 | Host acknowledge of the line interrupt |
| buf_we | output | 1 | Line buffer write enable |
| buf_data | output | DATA_W | Line buffer write data |
| irq | output | 1 | Line-ready interrupt request |
| phase | output | PH_W | Line phase of the current or next capture |
| ovr_flag | output | 1 | Sticky overrun flag |
| len_err | output | 1 | Sticky line length error flag |

## Verification
The properties assume that the decoder keeps href low while vsync is high. They also assume that field_odd is steady for a whole field and that each href burst is contiguous. The stimulus builds fields line by line from tasks that respect these rules. Randomness enters only through the gaps between lines. Those gaps are always long enough for an acknowledge to land before the next line, except in the overrun case, where acknowledges are withheld on purpose.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ARMED = 2'd1,
    CS_ODD   = 2'd2,
    CS_EVEN  = 2'd3
  } cap_state_t;
endpackage

// File: rtl/plc_line_tracker.sv
module plc_line_tracker #(
  parameter int LINES_PER_FIELD = 288,
  parameter int CNT_W = $clog2(LINES_PER_FIELD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             href,
  input  logic             vsync,
  output logic             href_rise,
  output logic             href_fall,
  output logic [CNT_W-1:0] line_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LINES_PER_FIELD);

  logic href_d;
  logic [CNT_W-1:0] cnt;

  assign href_rise = href & ~href_d;
  assign href_fall = ~href & href_d;
  assign line_idx  = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      href_d <= 1'b0;
      cnt    <= '0;
    end else begin
      href_d <= href;
      if (vsync)
        cnt <= '0;
      else if (href_rise && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/plc_sequencer.sv
module plc_sequencer
  import plc_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vsync,
  input  logic            field_odd,
  input  logic            cap_req,
  output logic            capturing,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  cap_state_t state;
  logic vsync_d;
  logic vs_rise, vs_fall;

  assign vs_rise   = vsync & ~vsync_d;
  assign vs_fall   = ~vsync & vsync_d;
  assign capturing = (state == CS_ODD) || (state == CS_EVEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CS_IDLE;
      vsync_d <= 1'b0;
      phase   <= '0;
    end else begin
      vsync_d <= vsync;
      unique case (state)
        CS_IDLE:  if (cap_req) state <= CS_ARMED;
        CS_ARMED: if (vs_fall && field_odd) state <= CS_ODD;
        CS_ODD:   if (vs_fall && !field_odd) state <= CS_EVEN;
        CS_EVEN: begin
          if (vs_rise) begin
            state <= CS_IDLE;
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
          end
        end
        default:  state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plc_line_gate.sv
module plc_line_gate #(
  parameter int BYTES_PER_LINE = 1440,
  parameter int DATA_W = 8,
  parameter int BC_W = $clog2(BYTES_PER_LINE + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              href,
  input  logic              href_rise,
  input  logic              href_fall,
  input  logic              pick,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              irq_ack,
  output logic              buf_we,
  output logic [DATA_W-1:0] buf_data,
  output logic              irq,
  output logic              ovr_flag,
  output logic              len_err
);
  localparam logic [BC_W-1:0] BC_NOM = BC_W'(BYTES_PER_LINE);
  localparam logic [BC_W-1:0] BC_SAT = BC_W'(BYTES_PER_LINE + 1);

  logic line_sel;
  logic we_c;
  logic line_done;
  logic [BC_W-1:0] bcnt;

  assign we_c      = href & (href_rise ? pick : line_sel);
  assign line_done = href_fall & line_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_sel <= 1'b0;
      bcnt     <= '0;
      buf_we   <= 1'b0;
      buf_data <= '0;
      irq      <= 1'b0;
      ovr_flag <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      buf_we   <= we_c;
      buf_data <= pix_data;
      if (href_rise) begin
        line_sel <= pick;
        bcnt     <= pick ? BC_W'(1) : '0;
      end else if (we_c && bcnt != BC_SAT) begin
        bcnt <= bcnt + 1'b1;
      end
      if (line_done) begin
        line_sel <= 1'b0;
        if (bcnt != BC_NOM) len_err <= 1'b1;
      end
      if (line_done)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;
      if (href_rise && pick && irq && !irq_ack)
        ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/phased_line_capture.sv
module phased_line_capture #(
  parameter int BYTES_PER_LINE  = 1440,
  parameter int LINES_PER_FIELD = 288,
  parameter int PHASES          = 4,
  parameter int DATA_W          = 8,
  localparam int PH_W  = $clog2(PHASES),
  localparam int CNT_W = $clog2(LINES_PER_FIELD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              href,
  input  logic              vsync,
  input  logic              field_odd,
  input  logic              cap_req,
  input  logic              irq_ack,
  output logic              buf_we,
  output logic [DATA_W-1:0] buf_data,
  output logic              irq,
  output logic [PH_W-1:0]   phase,
  output logic              ovr_flag,
  output logic              len_err
);
  logic href_rise, href_fall;
  logic [CNT_W-1:0] line_idx;
  logic capturing;
  logic pick;
  logic [CNT_W-1:0] line_mod;

  plc_line_tracker #(
    .LINES_PER_FIELD(LINES_PER_FIELD),
    .CNT_W(CNT_W)
  ) trk_i (
    .clk(clk), .rst(rst), .href(href), .vsync(vsync),
    .href_rise(href_rise), .href_fall(href_fall), .line_idx(line_idx)
  );

  plc_sequencer #(
    .PHASES(PHASES),
    .PH_W(PH_W)
  ) seq_i (
    .clk(clk), .rst(rst), .vsync(vsync), .field_odd(field_odd),
    .cap_req(cap_req), .capturing(capturing), .phase(phase)
  );

  assign line_mod = line_idx % CNT_W'(PHASES);
  assign pick     = capturing && (line_mod == CNT_W'(phase));

  plc_line_gate #(
    .BYTES_PER_LINE(BYTES_PER_LINE),
    .DATA_W(DATA_W)
  ) gate_i (
    .clk(clk), .rst(rst), .href(href), .href_rise(href_rise),
    .href_fall(href_fall), .pick(pick), .pix_data(pix_data),
    .irq_ack(irq_ack), .buf_we(buf_we), .buf_data(buf_data),
    .irq(irq), .ovr_flag(ovr_flag), .len_err(len_err)
  );
endmodule

// File: rtl/phased_line_capture_chk.sv
module phased_line_capture_chk #(
  parameter int PH_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            href,
  input logic            vsync,
  input logic            irq_ack,
  input logic            buf_we,
  input logic            irq,
  input logic [PH_W-1:0] phase,
  input logic            ovr_flag,
  input logic            len_err
);
  AST_WE_NEEDS_HREF: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(href)); // R4
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq); // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> (phase == $past(phase) + 1'b1)); // R5
  AST_PHASE_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> $past(vsync)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |=> ovr_flag); // R8
  AST_LEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err); // R9
endmodule

bind phased_line_capture phased_line_capture_chk chk_i (
  .clk(clk), .rst(rst), .href(href), .vsync(vsync), .irq_ack(irq_ack),
  .buf_we(buf_we), .irq(irq), .phase(phase), .ovr_flag(ovr_flag),
  .len_err(len_err)
);

// File: tb/phased_line_capture_tb_top.sv
module phased_line_capture_tb_top;
  localparam int BYTES = 8;
  localparam int LINES = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pix_data = '0;
  logic href = 1'b0, vsync = 1'b0, field_odd = 1'b0, cap_req = 1'b0, irq_ack = 1'b0;
  logic buf_we, irq, ovr_flag, len_err;
  logic [7:0] buf_data;
  logic [1:0] phase;

  int n_chk = 0, n_fail = 0;
  int got [2][16];
  int hits [2][16];
  int irq_cnt = 0, mism = 0;
  logic irq_q = 1'b0;
  bit ack_en = 1'b1;
  bit done = 1'b0;
  int seed_dummy;

  always #4 clk = ~clk;

  phased_line_capture #(.BYTES_PER_LINE(BYTES), .LINES_PER_FIELD(LINES)) dut_i (
    .clk(clk), .rst(rst), .pix_data(pix_data), .href(href), .vsync(vsync),
    .field_odd(field_odd), .cap_req(cap_req), .irq_ack(irq_ack),
    .buf_we(buf_we), .buf_data(buf_data), .irq(irq), .phase(phase),
    .ovr_flag(ovr_flag), .len_err(len_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (buf_we) begin
        if (int'(buf_data[2:0]) != (got[buf_data[7]][buf_data[6:3]] % 8)) mism++;
        got[buf_data[7]][buf_data[6:3]]++;
      end
      if (irq && !irq_q) irq_cnt++;
    end
    irq_q <= irq;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    irq_ack = ack_en & irq;
  endtask

  task automatic clear_got();
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 16; l++) got[f][l] = 0;
    irq_cnt = 0;
  endtask

  function automatic int total_got();
    int s = 0;
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 16; l++) s += got[f][l];
    return s;
  endfunction

  function automatic int exp_bytes(input int l, input int ph);
    return ((l % 4) == ph) ? BYTES : 0;
  endfunction

  task automatic sync(input bit odd, input bit req);
    field_odd = odd;
    vsync = 1'b1;
    tick();
    cap_req = req;
    tick();
    cap_req = 1'b0;
    tick();
    vsync = 1'b0;
    repeat (3) tick();
  endtask

  task automatic lines(input bit odd, input int bad_line, input int bad_len);
    for (int l = 0; l < LINES; l++) begin
      int len;
      len = (l == bad_line) ? bad_len : BYTES;
      for (int b = 0; b < len; b++) begin
        href = 1'b1;
        pix_data = {odd, l[3:0], b[2:0]};
        tick();
      end
      href = 1'b0;
      pix_data = '0;
      repeat (3 + ($urandom % 4)) tick();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    clear_got();
  endtask

  task automatic check_capture(input int ph);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < LINES; l++) begin
        chk(got[f][l] == exp_bytes(l, ph), "R4 bytes per line", got[f][l], exp_bytes(l, ph));
        if (got[f][l] > 0) hits[f][l]++;
      end
    chk(irq_cnt == 2 * LINES / 4, "R7 irq per capture", irq_cnt, 2 * LINES / 4);
    clear_got();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 16; l++) hits[f][l] = 0;
    clear_got();
    repeat (3) tick();
    chk(!buf_we && !irq && !ovr_flag && !len_err, "R1 outputs in reset",
        {buf_we, irq, ovr_flag, len_err}, 0);
    chk(phase == 2'd0, "R1 phase in reset", phase, 0);
    rst = 1'b0;
    tick();
    chk(!buf_we && !irq && phase == 2'd0, "R1 after reset", {buf_we, irq, phase}, 0);

    // R2: unrequested odd field
    sync(1'b1, 1'b0);
    lines(1'b1, -1, 0);
    chk(total_got() == 0, "R2 no request no write", total_got(), 0);
    // R3: request armed before an even field start
    sync(1'b0, 1'b1);
    lines(1'b0, -1, 0);
    chk(total_got() == 0, "R3 even start does not begin", total_got(), 0);

    for (int k = 0; k < 4; k++) begin
      sync(1'b1, k != 0);
      if (k != 0) begin
        check_capture(k - 1);
        chk(phase == 2'(k), "R5 phase step", phase, k);
      end else begin
        chk(phase == 2'd0, "R5 phase steady before first end", phase, 0);
      end
      lines(1'b1, -1, 0);
      sync(1'b0, 1'b0);
      chk(phase == 2'(k), "R5 phase steady mid capture", phase, k);
      lines(1'b0, -1, 0);
    end
    sync(1'b1, 1'b0);
    check_capture(3);
    chk(phase == 2'd0, "R5 phase wraps 3 to 0", phase, 0);
    lines(1'b1, -1, 0);
    chk(total_got() == 0, "R2 no write after capture end", total_got(), 0);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < LINES; l++)
        chk(hits[f][l] == 1, "R6 union covers each line once", hits[f][l], 1);
    chk(mism == 0, "R4 byte order and data", mism, 0);
    chk(!ovr_flag, "R8 no overrun with timely ack", ovr_flag, 0);
    chk(!len_err, "R9 no error on nominal lines", len_err, 0);

    // R7/R8: withheld acknowledge
    ack_en = 1'b0;
    do_reset();
    sync(1'b1, 1'b1);
    lines(1'b1, -1, 0);
    chk(irq == 1'b1, "R7 irq held without ack", irq, 1);
    chk(ovr_flag == 1'b1, "R8 overrun set", ovr_flag, 1);
    chk(got[1][0] == BYTES, "R4 capture at odd start after request", got[1][0], BYTES);
    ack_en = 1'b1;
    repeat (3) tick();
    chk(irq == 1'b0, "R7 irq cleared by ack", irq, 0);
    chk(ovr_flag == 1'b1, "R8 overrun sticky", ovr_flag, 1);

    // R9: short and long selected lines
    do_reset();
    sync(1'b1, 1'b1);
    lines(1'b1, 0, BYTES - 1);
    chk(len_err == 1'b1, "R9 short line", len_err, 1);
    do_reset();
    chk(len_err == 1'b0, "R1 len_err cleared by reset", len_err, 0);
    sync(1'b1, 1'b1);
    lines(1'b1, 3, BYTES + 1);
    chk(len_err == 1'b0, "R9 long unselected line ignored", len_err, 0);
    do_reset();
    sync(1'b1, 1'b1);
    lines(1'b1, 4, BYTES + 1);
    chk(len_err == 1'b1, "R9 long line", len_err, 1);

    finish_run();
  end
endmodule